// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block governs the power-down state of a small microcontroller core. When the core executes its sleep instruction, the block stops the oscillator and the core clock. It clears the watchdog and updates two status bits: a time-out flag and a power-down flag. It then waits for a wake event that needs no core clock. A wake event is either a reset request (external pin or watchdog time-out) or an enabled interrupt from a source that can work without the core clock.

On a wake, the block selects one of three exits. A reset request produces a full core reset. An interrupt wake always runs the prefetched instruction that follows the sleep instruction. If interrupts are globally enabled, one dummy cycle then follows, during which the core branches to the interrupt vector. If they are globally disabled, execution simply continues in line. Crystal-type oscillator modes hold the core for a start-up interval after the oscillator restarts. RC and external-clock modes resume at once.

An interrupt that is already pending and enabled when the sleep instruction executes cancels the sleep immediately. The global interrupt-disable bit never blocks a wake.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A `sleep_exec` strobe in the run state, with no reset request in the same cycle, leads in the next cycle to `osc_en`=0, `core_run`=0, `stat_pd`=0, `stat_to`=1, and a one-cycle `wdt_clr` pulse.
- R2: While asleep, interrupt source n wakes the block only if `irq_flag[n]` and `irq_en[n]` are both 1 and bit n of the wake-capable mask is set. The default mask marks sources 0 to 5 of 8. `glob_int_dis` has no effect on this.
- R3: If any source, masked or not, has flag and enable set in the cycle of `sleep_exec`, the next cycle is the resume cycle with `osc_en`=1. `stat_pd` reads 0 and `stat_to` reads 1.
- R4: An interrupt wake with `glob_int_dis`=1 gives one cycle of `resume_pulse` with `core_run`=1, then plain run with no `branch_vec`.
- R5: An interrupt wake with `glob_int_dis`=0 gives the resume cycle, then exactly one cycle of `branch_vec`=1 (a dummy cycle; the vector address is 0x0004), then plain run.
- R6: The `osc_mode` encoding is 00 low-frequency crystal, 01 crystal, 10 RC, 11 external clock. In modes 00 and 01, a wake holds `osc_en`=1 and `core_run`=0 for exactly 1024 cycles before the exit cycle. In modes 10 and 11, the exit comes in the cycle right after the wake event.
- R7: `wdt_clr` pulses for one cycle on every wake from sleep, whatever the source.
- R8: A `wdt_timeout` or `ext_rst_req` while asleep ends the sleep with a one-cycle `core_reset` pulse, after the start-up hold in crystal modes, and then plain run. No `resume_pulse` or `branch_vec` is produced.
- R9: `stat_to` is cleared only by `wdt_timeout`. An external reset leaves `stat_to` and `stat_pd` unchanged.
- R10: After power-on reset (`rst_n` low), the block is in run: `osc_en`=1, `core_run`=1, `stat_to`=1, `stat_pd`=1, and all pulse outputs are 0.
- R11: A reset request outside sleep gives a `core_reset` pulse in the next cycle. A `sleep_exec` in that same cycle is ignored: `osc_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_exec | input | 1 | One-cycle strobe: the sleep instruction executes |
| ext_rst_req | input | 1 | External reset request |
| wdt_timeout | input | 1 | Watchdog time-out request |
| irq_flag | input | N_IRQ | Interrupt flags, one per source |
| irq_en | input | N_IRQ | Interrupt enables, one per source |
| glob_int_dis | input | 1 | Global interrupt disable |
| osc_mode | input | 2 | Oscillator mode (see R6) |
| osc_en | output | 1 | Oscillator driver enable |
| core_run | output | 1 | Core clock run enable |
| wdt_clr | output | 1 | Watchdog and postscaler clear pulse |
| stat_to | output | 1 | Time-out status bit |
| stat_pd | output | 1 | Power-down status bit |
| core_reset | output | 1 | One-cycle full reset of the core |
| resume_pulse | output | 1 | Cycle in which the instruction after sleep executes |
| branch_vec | output | 1 | Dummy cycle; the core branches to the interrupt vector |

## Verification
A wrong state in the sequencer shows at the ports within one cycle. Examples are `core_run` high during sleep, a missing or extra `resume_pulse`, or `branch_vec` under the wrong disable setting. A wrong start-up count moves the exit cycle and is seen only at the end of the 1024-cycle hold, so the hold length is counted exactly. A wrongly latched wake cause turns an expected `core_reset` into a `resume_pulse` at the exit cycle. Status-bit errors appear in the cycle after the sleep strobe or the time-out.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_SLEEP    = 3'd1,
    ST_OST_WAIT = 3'd2,
    ST_RESUME   = 3'd3,
    ST_VECTOR   = 3'd4
  } swc_state_e;

  typedef enum logic [1:0] {
    OSC_LF  = 2'b00,
    OSC_XT  = 2'b01,
    OSC_RC  = 2'b10,
    OSC_EXT = 2'b11
  } osc_mode_e;

  // Crystal-type modes need the start-up hold after the oscillator restarts.
  function automatic logic needs_startup(input logic [1:0] mode);
    return (mode == OSC_LF) || (mode == OSC_XT);
  endfunction

  // Terminal count of a start-up timer lasting 'cycles' clocks.
  function automatic int unsigned startup_last(input int unsigned cycles);
    return cycles - 1;
  endfunction

endpackage

// File: rtl/swc_wake_detect.sv
module swc_wake_detect #(
  parameter int unsigned N_IRQ        = 8,
  parameter logic [31:0] WAKE_CAPABLE = 32'h0000_003F
) (
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             pend_any,
  output logic             pend_sleep
);

  logic [N_IRQ-1:0] hit;
  logic [N_IRQ-1:0] hit_sleep;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign hit[i] = irq_flag[i] & irq_en[i];
    if (WAKE_CAPABLE[i]) begin : g_cap
      assign hit_sleep[i] = hit[i];
    end else begin : g_nocap
      assign hit_sleep[i] = 1'b0;
    end
  end

  assign pend_any   = |hit;
  assign pend_sleep = |hit_sleep;

endmodule

// File: rtl/swc_ost_timer.sv
module swc_ost_timer #(
  parameter int unsigned OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);
  import swc_pkg::*;

  localparam int unsigned CNT_W = $clog2(OST_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(startup_last(OST_CYCLES));

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + 1'b1;
  end

  assign done = active && (cnt_q == LAST);

  AST_OST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= LAST)); // R6

endmodule

// File: rtl/swc_status.sv
module swc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_ok,
  input  logic wdt_to,
  output logic stat_to,
  output logic stat_pd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_to <= 1'b1;
      stat_pd <= 1'b1;
    end else begin
      if (wdt_to)        stat_to <= 1'b0;
      else if (sleep_ok) stat_to <= 1'b1;
      if (sleep_ok)      stat_pd <= 1'b0;
    end
  end

  AST_TO_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_to) |-> $past(wdt_to)); // R9

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int unsigned N_IRQ        = 8,
  parameter logic [31:0] WAKE_CAPABLE = 32'h0000_003F,
  parameter int unsigned OST_CYCLES   = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_exec,
  input  logic             ext_rst_req,
  input  logic             wdt_timeout,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             glob_int_dis,
  input  logic [1:0]       osc_mode,
  output logic             osc_en,
  output logic             core_run,
  output logic             wdt_clr,
  output logic             stat_to,
  output logic             stat_pd,
  output logic             core_reset,
  output logic             resume_pulse,
  output logic             branch_vec
);
  import swc_pkg::*;

  swc_state_e state_q, state_d;
  logic cause_rst_q, cause_rst_d;
  logic rst_pulse_q, rst_pulse_d;
  logic clr_pulse_q, clr_pulse_d;
  logic sleep_ok, ost_start, ost_done;
  logic pend_any, pend_sleep;
  logic rst_evt;

  assign rst_evt = ext_rst_req | wdt_timeout;

  swc_wake_detect #(.N_IRQ(N_IRQ), .WAKE_CAPABLE(WAKE_CAPABLE)) u_wake (
    .irq_flag   (irq_flag),
    .irq_en     (irq_en),
    .pend_any   (pend_any),
    .pend_sleep (pend_sleep)
  );

  swc_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (ost_start),
    .active (state_q == ST_OST_WAIT),
    .done   (ost_done)
  );

  swc_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_ok (sleep_ok),
    .wdt_to   (wdt_timeout),
    .stat_to  (stat_to),
    .stat_pd  (stat_pd)
  );

  always_comb begin
    state_d     = state_q;
    cause_rst_d = cause_rst_q;
    rst_pulse_d = 1'b0;
    clr_pulse_d = 1'b0;
    sleep_ok    = 1'b0;
    ost_start   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (rst_evt) begin
          rst_pulse_d = 1'b1;
        end else if (sleep_exec) begin
          sleep_ok    = 1'b1;
          clr_pulse_d = 1'b1;
          state_d     = pend_any ? ST_RESUME : ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (rst_evt || pend_sleep) begin
          clr_pulse_d = 1'b1;
          cause_rst_d = rst_evt;
          if (needs_startup(osc_mode)) begin
            ost_start = 1'b1;
            state_d   = ST_OST_WAIT;
          end else if (rst_evt) begin
            rst_pulse_d = 1'b1;
            state_d     = ST_RUN;
          end else begin
            state_d = ST_RESUME;
          end
        end
      end
      ST_OST_WAIT: begin
        cause_rst_d = cause_rst_q | rst_evt;
        if (ost_done) begin
          if (cause_rst_d) begin
            rst_pulse_d = 1'b1;
            state_d     = ST_RUN;
          end else begin
            state_d = ST_RESUME;
          end
        end
      end
      ST_RESUME: begin
        if (rst_evt) begin
          rst_pulse_d = 1'b1;
          state_d     = ST_RUN;
        end else begin
          state_d = glob_int_dis ? ST_RUN : ST_VECTOR;
        end
      end
      ST_VECTOR: begin
        rst_pulse_d = rst_evt;
        state_d     = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      cause_rst_q <= 1'b0;
      rst_pulse_q <= 1'b0;
      clr_pulse_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cause_rst_q <= cause_rst_d;
      rst_pulse_q <= rst_pulse_d;
      clr_pulse_q <= clr_pulse_d;
    end
  end

  assign osc_en       = (state_q != ST_SLEEP);
  assign core_run     = (state_q == ST_RUN) || (state_q == ST_RESUME) || (state_q == ST_VECTOR);
  assign wdt_clr      = clr_pulse_q;
  assign core_reset   = rst_pulse_q;
  assign resume_pulse = (state_q == ST_RESUME);
  assign branch_vec   = (state_q == ST_VECTOR);

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_exec && !rst_evt) |=> (!stat_pd && stat_to && wdt_clr)); // R1
  AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !pend_sleep && !rst_evt) |=> (state_q == ST_SLEEP && !core_run)); // R2
  AST_OST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OST_WAIT && !ost_done) |=> (state_q == ST_OST_WAIT && osc_en && !core_run)); // R6
  AST_WAKE_CLEARS_WDT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_SLEEP && state_q != ST_SLEEP) |-> wdt_clr); // R7
  AST_VECTOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    branch_vec |-> ($past(state_q) == ST_RESUME && !$past(glob_int_dis))); // R5
  AST_ONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_reset, resume_pulse, branch_vec})); // R8

endmodule

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;

  localparam int unsigned N_IRQ = 8;
  localparam int unsigned OST_EXPECT = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_exec = 1'b0, ext_rst_req = 1'b0, wdt_timeout = 1'b0;
  logic [N_IRQ-1:0] irq_flag = '0, irq_en = '0;
  logic glob_int_dis = 1'b1;
  logic [1:0] osc_mode = 2'b10;
  logic osc_en, core_run, wdt_clr, stat_to, stat_pd, core_reset, resume_pulse, branch_vec;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sleep_wake_ctrl u_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .ext_rst_req(ext_rst_req),
    .wdt_timeout(wdt_timeout), .irq_flag(irq_flag), .irq_en(irq_en),
    .glob_int_dis(glob_int_dis), .osc_mode(osc_mode), .osc_en(osc_en),
    .core_run(core_run), .wdt_clr(wdt_clr), .stat_to(stat_to), .stat_pd(stat_pd),
    .core_reset(core_reset), .resume_pulse(resume_pulse), .branch_vec(branch_vec)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic go_sleep();
    sleep_exec = 1'b1;
    step();
    sleep_exec = 1'b0;
  endtask

  task automatic wake_irq(input int src);
    irq_flag[src] = 1'b1;
    irq_en[src]   = 1'b1;
    step();
    irq_flag = '0;
    irq_en   = '0;
  endtask

  function automatic int count_hold_limit();
    return OST_EXPECT + 100;
  endfunction

  task automatic t_reset();
    check("R10", "osc_en", osc_en, 1);
    check("R10", "core_run", core_run, 1);
    check("R10", "stat_to", stat_to, 1);
    check("R10", "stat_pd", stat_pd, 1);
    check("R10", "pulses", {core_reset, wdt_clr, resume_pulse, branch_vec}, 0);
  endtask

  task automatic t_sleep_inline();
    osc_mode = 2'b10; glob_int_dis = 1'b1;
    go_sleep();
    check("R1", "osc_en", osc_en, 0);
    check("R1", "core_run", core_run, 0);
    check("R1", "stat_pd", stat_pd, 0);
    check("R1", "stat_to", stat_to, 1);
    check("R1", "wdt_clr", wdt_clr, 1);
    step();
    check("R1", "wdt_clr single", wdt_clr, 0);
    wake_irq(0);
    check("R4", "resume_pulse", resume_pulse, 1);
    check("R4", "core_run", core_run, 1);
    check("R7", "wdt_clr on irq wake", wdt_clr, 1);
    step();
    check("R4", "no branch", branch_vec, 0);
    check("R4", "resume ends", resume_pulse, 0);
    check("R4", "running", core_run, 1);
  endtask

  task automatic t_vector();
    osc_mode = 2'b10; glob_int_dis = 1'b0;
    go_sleep();
    wake_irq(2);
    check("R5", "resume first", resume_pulse, 1);
    step();
    check("R5", "branch_vec", branch_vec, 1);
    check("R5", "core_run in dummy", core_run, 1);
    step();
    check("R5", "branch single", branch_vec, 0);
    check("R5", "back to run", core_run & osc_en, 1);
    glob_int_dis = 1'b1;
  endtask

  task automatic t_crystal_hold();
    int n;
    osc_mode = 2'b01;
    go_sleep();
    wake_irq(1);
    check("R6", "osc on during hold", osc_en, 1);
    n = 0;
    while (!core_run && n < count_hold_limit()) begin
      n++;
      step();
    end
    check("R6", "hold cycles", n, OST_EXPECT);
    check("R6", "exit is resume", resume_pulse, 1);
    step();
    osc_mode = 2'b11;
    go_sleep();
    wake_irq(3);
    check("R6", "ext clock no hold", resume_pulse, 1);
    step();
    osc_mode = 2'b10;
  endtask

  task automatic t_gates();
    go_sleep();
    irq_flag[0] = 1'b1; glob_int_dis = 1'b0;
    repeat (4) step();
    check("R2", "flag without enable", core_run, 0);
    irq_flag = '0;
    irq_flag[7] = 1'b1; irq_en[7] = 1'b1;
    repeat (4) step();
    check("R2", "non-wake source", core_run, 0);
    irq_flag = '0; irq_en = '0; glob_int_dis = 1'b1;
    wake_irq(5);
    check("R2", "wake with global disable set", resume_pulse, 1);
    step();
    irq_flag[7] = 1'b1; irq_en[7] = 1'b1;
    go_sleep();
    check("R3", "immediate resume", resume_pulse, 1);
    check("R3", "osc stays on", osc_en, 1);
    check("R3", "stat_pd", stat_pd, 0);
    check("R3", "stat_to", stat_to, 1);
    irq_flag = '0; irq_en = '0;
    step();
  endtask

  task automatic t_wdt_wake();
    osc_mode = 2'b10;
    go_sleep();
    wdt_timeout = 1'b1;
    step();
    wdt_timeout = 1'b0;
    check("R8", "core_reset", core_reset, 1);
    check("R8", "no resume", resume_pulse, 0);
    check("R9", "stat_to cleared", stat_to, 0);
    check("R9", "stat_pd", stat_pd, 0);
    check("R7", "wdt_clr on wdt wake", wdt_clr, 1);
    step();
    check("R8", "reset single", core_reset, 0);
  endtask

  task automatic t_ext_reset_crystal();
    int n;
    osc_mode = 2'b00;
    go_sleep();
    ext_rst_req = 1'b1;
    step();
    ext_rst_req = 1'b0;
    n = 0;
    while (!core_run && n < count_hold_limit()) begin
      n++;
      step();
    end
    check("R6", "hold before reset", n, OST_EXPECT);
    check("R8", "core_reset after hold", core_reset, 1);
    check("R8", "no resume", resume_pulse, 0);
    check("R9", "ext reset keeps to", stat_to, 1);
    check("R9", "ext reset keeps pd", stat_pd, 0);
    step();
    osc_mode = 2'b10;
  endtask

  task automatic t_run_reset();
    ext_rst_req = 1'b1; sleep_exec = 1'b1;
    step();
    ext_rst_req = 1'b0; sleep_exec = 1'b0;
    check("R11", "core_reset", core_reset, 1);
    check("R11", "sleep ignored", osc_en, 1);
    check("R11", "pd unchanged", stat_pd, 0);
    step();
    check("R11", "still running", core_run & osc_en, 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_sleep_inline();
    t_vector();
    t_crystal_hold();
    t_gates();
    t_wdt_wake();
    t_ext_reset_crystal();
    t_run_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule